// File: doc/BRIEF.md
# Prescaled Capture Timer

This block is a 16-bit free-running timer counter fed from the bus clock through a power-of-two prescaler. A byte-wide register port exposes several registers. The counter is visible as a high byte and a low byte. A control register holds the prescaler select and the overflow interrupt enable. A status register holds the overflow flag, which is cleared by writing a 1 to it. Three single-cycle capture strobes each copy the current count into a 16-bit capture register of their own. The block raises an overflow interrupt request when the flag is set and the interrupt is enabled.

The prescaler select can be changed only in a short window after reset. A two-state controller tracks that window. It starts in `LK_OPEN`, where writes to the select bits are accepted. On the clock edge that completes the 64th cycle after reset it takes the `LK_EXPIRE` transition into `LK_LOCKED`. It then stays in `LK_LOCKED` until the next reset (`LK_HOLD`). While it is locked, control-register writes still update every bit except the select bits.

Register addresses: 0 is the counter high byte, 1 the counter low byte, 2 the control register and 3 the status register. Addresses 4 and 5 hold the high and low bytes of capture 0, 6 and 7 those of capture 1, and 8 and 9 those of capture 2.

Top module: `ptmr_top`

## Requirements
- R1: While reset is asserted (active-low, asynchronous), the counter, control register, status register, low-byte holding register and all capture registers are cleared. The prescaler therefore runs at divide-by-1, and `ovf_irq` is 0.
- R2: Control bits [1:0] select the divide ratio: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16. The prescaler phase runs from reset whatever the select is. With divide D in force, the counter steps on each clock edge whose number, counted from the first edge after reset release, is a multiple of D.
- R3: The counter wraps from 0xFFFF to 0x0000. On the edge where it wraps, status bit 7 (the overflow flag) is set.
- R4: A write to address 3 with data bit 7 = 1 clears the overflow flag, and a write with bit 7 = 0 leaves it unchanged. If a wrap falls on the same edge as a clearing write, the flag ends up set. The other status bits always read 0.
- R5: A control-register write on edges 1 to 64 after reset updates all eight bits. From edge 65 onward, a write updates bits [7:2] and leaves the select bits [1:0] unchanged.
- R6: `ovf_irq` is 1 exactly when the overflow flag is set and control bit 7 (the overflow interrupt enable) is 1.
- R7: A read of address 0 returns the counter high byte and stores the counter low byte from that same cycle. A later read of address 1 returns that stored byte, not the live low byte.
- R8: A one-cycle pulse on `capt_strobe[i]` stores the count of that cycle into capture register i. The high byte is read at address 4+2i and the low byte at 4+2i+1.
- R9: If a capture register byte is read in the same cycle as its strobe, the read returns the newly captured byte.
- R10: Read data appears on `bus_rdata` one clock after the read request. Unmapped addresses (10 and above) read as 0. Writes to addresses 0, 1 and 4 to 9 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| capt_strobe | input | 3 | Capture strobes, one per capture register |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench tests the edges of the select window with a write on edge 64, which must take effect, and a write on edge 65, which must not. A window that is one cycle off would keep the wrong divide ratio. It clears the flag on the exact edge of a wrap, where a design that gave the clear priority would lose an overflow. It reads a capture register in the cycle of its strobe, where a design without the bypass would return the stale value. It reads the low byte several cycles after the high byte, which exposes a design that returns the live count and so tears the 16-bit value. The divide ratios are checked against an edge-numbered model, so a prescaler whose phase restarts when the select changes, or that divides by the wrong amount, would miscompare.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int PRE_W  = 4;
    localparam int SEL_W  = 2;

    localparam int ADR_CNT_HI   = 0;
    localparam int ADR_CNT_LO   = 1;
    localparam int ADR_CTRL     = 2;
    localparam int ADR_STAT     = 3;
    localparam int ADR_CAP_BASE = 4;

    localparam int CTRL_IRQ_EN_BIT = 7;
    localparam int STAT_OVF_BIT    = 7;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_LOCKED = 1'b1
    } lock_state_e;

    // Low prescaler bits that must all be one for a counter step.
    function automatic logic [PRE_W-1:0] sel_to_mask(input logic [SEL_W-1:0] sel);
        logic [PRE_W-1:0] m;
        unique case (sel)
            2'b00:   m = 4'b0000;
            2'b01:   m = 4'b0011;
            2'b10:   m = 4'b0111;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ptmr_lock_fsm.sv
module ptmr_lock_fsm
    import ptmr_pkg::*;
#(
    parameter int LOCK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic sel_open
);
    localparam int LK_W = $clog2(LOCK_CYCLES + 1);

    lock_state_e      state_q, state_d;
    logic [LK_W-1:0]  cyc_q;

    // State register and cycle count since reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_OPEN;
            cyc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == LK_OPEN)
                cyc_q <= cyc_q + 1'b1;
        end
    end

    // Transitions: LK_EXPIRE (open -> locked), LK_HOLD (locked -> locked).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (cyc_q == LK_W'(LOCK_CYCLES - 1)) state_d = LK_LOCKED;
            LK_LOCKED: state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    // Output process.
    always_comb begin
        unique case (state_q)
            LK_OPEN:   sel_open = 1'b1;
            default:   sel_open = 1'b0;
        endcase
    end

    // R5: once locked the window never reopens before reset
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == LK_LOCKED |=> state_q == LK_LOCKED);

    // R5: the open window never outlasts its cycle budget
    a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == LK_OPEN |-> cyc_q < LK_W'(LOCK_CYCLES));

endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
    import ptmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] need;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    always_comb begin
        need = sel_to_mask(sel);
        tick = (phase_q & need) == need;
    end

    // R2: divide-by-1 steps on every cycle
    a_r2_div1_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 2'b00 |-> tick);

    // R2: divide-by-16 never steps twice in a row
    a_r2_div16_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11 && tick) |=> !tick);

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
    import ptmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;
    assign wrap  = tick && (cnt_q == {CNT_W{1'b1}});

    // R3: a wrap lands on zero
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt_q == '0);

    // R2: the count holds between prescaler steps
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

endmodule

// File: rtl/ptmr_capture_bank.sv
module ptmr_capture_bank
    import ptmr_pkg::*;
#(
    parameter int NUM_CAPT = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_CAPT-1:0]               strobe,
    input  logic [CNT_W-1:0]                  count,
    output logic [NUM_CAPT-1:0][CNT_W-1:0]    capt_q
);
    for (genvar g = 0; g < NUM_CAPT; g++) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         capt_q[g] <= '0;
            else if (strobe[g]) capt_q[g] <= count;
        end

        // R8: a strobe stores the count present in its cycle
        a_r8_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
            strobe[g] |=> capt_q[g] == $past(count));

        // R8: without a strobe the register holds
        a_r8_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !strobe[g] |=> $stable(capt_q[g]));
    end

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int NUM_CAPT    = 3,
    parameter int LOCK_CYCLES = 64,
    parameter int ADDR_W      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [NUM_CAPT-1:0] capt_strobe,
    output logic                ovf_irq
);
    localparam int HI_LSB = CNT_W - BYTE_W;

    logic                          sel_open;
    logic                          tick;
    logic                          wrap;
    logic [CNT_W-1:0]              count;
    logic [NUM_CAPT-1:0][CNT_W-1:0] capt_q;
    logic [BYTE_W-1:0]             ctrl_q;
    logic                          ovf_q;
    logic [BYTE_W-1:0]             lo_hold_q;
    logic [BYTE_W-1:0]             rdata_q;
    logic [BYTE_W-1:0]             rd_val;
    logic                          wr_ctrl, wr_stat, rd_cnt_hi;

    ptmr_lock_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_open (sel_open)
    );

    ptmr_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (ctrl_q[SEL_W-1:0]),
        .tick  (tick)
    );

    ptmr_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (count),
        .wrap  (wrap)
    );

    ptmr_capture_bank #(.NUM_CAPT(NUM_CAPT)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (capt_strobe),
        .count  (count),
        .capt_q (capt_q)
    );

    assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
    assign wr_stat   = bus_wr && (bus_addr == ADDR_W'(ADR_STAT));
    assign rd_cnt_hi = bus_rd && (bus_addr == ADDR_W'(ADR_CNT_HI));

    // Control register: select bits only while the window is open.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q[BYTE_W-1:SEL_W] <= bus_wdata[BYTE_W-1:SEL_W];
            if (sel_open)
                ctrl_q[SEL_W-1:0] <= bus_wdata[SEL_W-1:0];
        end
    end

    // Overflow flag: a wrap beats a clearing write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               ovf_q <= 1'b0;
        else if (wrap)                            ovf_q <= 1'b1;
        else if (wr_stat && bus_wdata[STAT_OVF_BIT]) ovf_q <= 1'b0;
    end

    // Low byte held by a high-byte read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         lo_hold_q <= '0;
        else if (rd_cnt_hi) lo_hold_q <= count[BYTE_W-1:0];
    end

    // Read mux; a capture in the same cycle is bypassed to the read.
    always_comb begin
        rd_val = '0;
        if (bus_addr == ADDR_W'(ADR_CNT_HI))      rd_val = count[CNT_W-1:HI_LSB];
        else if (bus_addr == ADDR_W'(ADR_CNT_LO)) rd_val = lo_hold_q;
        else if (bus_addr == ADDR_W'(ADR_CTRL))   rd_val = ctrl_q;
        else if (bus_addr == ADDR_W'(ADR_STAT))   rd_val = {ovf_q, {(BYTE_W-1){1'b0}}};
        else begin
            for (int i = 0; i < NUM_CAPT; i++) begin
                if (bus_addr == ADDR_W'(ADR_CAP_BASE + 2 * i))
                    rd_val = capt_strobe[i] ? count[CNT_W-1:HI_LSB]
                                            : capt_q[i][CNT_W-1:HI_LSB];
                else if (bus_addr == ADDR_W'(ADR_CAP_BASE + 2 * i + 1))
                    rd_val = capt_strobe[i] ? count[BYTE_W-1:0]
                                            : capt_q[i][BYTE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;
    assign ovf_irq   = ovf_q & ctrl_q[CTRL_IRQ_EN_BIT];

    // R5: outside the window the select bits never move
    a_r5_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_open |=> $stable(ctrl_q[SEL_W-1:0]));

    // R3: every wrap leaves the overflow flag set
    a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_q);

    // R4: the flag only rises on a wrap
    a_r4_flag_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> !$rose(ovf_q));

    // R6: no request without the enable
    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CTRL_IRQ_EN_BIT] |-> !ovf_irq);

endmodule

// File: tb/ptmr_top_tb.sv
module ptmr_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] capt_strobe = '0;
    logic       ovf_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state (from the requirements).
    int          edge_n = 0;
    int          m_div = 1;
    logic [15:0] m_cnt = '0;
    logic [15:0] m_at_rd = '0;
    logic [15:0] m_cap [3];
    logic [7:0]  exp_lo = '0;

    always #4 clk = ~clk;

    ptmr_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .capt_strobe (capt_strobe),
        .ovf_irq     (ovf_irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            edge_n = 0;
            m_div  = 1;
            m_cnt  = '0;
            for (int i = 0; i < 3; i++) m_cap[i] = '0;
        end else begin
            edge_n = edge_n + 1;
            if (bus_rd) m_at_rd = m_cnt;
            for (int i = 0; i < 3; i++)
                if (capt_strobe[i]) m_cap[i] = m_cnt;
            if (edge_n % m_div == 0) m_cnt = m_cnt + 16'd1;
            if (bus_wr && bus_addr == 4'd2 && edge_n <= 64)
                case (bus_wdata[1:0])
                    2'b00: m_div = 1;
                    2'b01: m_div = 4;
                    2'b10: m_div = 8;
                    default: m_div = 16;
                endcase
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0; capt_strobe = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_count(input string tag);
        logic [7:0] d;
        bus_read(4'd0, d);
        chk({tag, " count hi"}, {8'h0, d}, {8'h0, m_at_rd[15:8]});
        exp_lo = m_at_rd[7:0];
        bus_read(4'd1, d);
        chk({tag, " count lo"}, {8'h0, d}, {8'h0, exp_lo});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rst_n = 1'b0;
        idle(2);
        chk("R1 irq in reset", {15'h0, ovf_irq}, 16'h0);
        chk("R1 rdata in reset", {8'h0, bus_rdata}, 16'h0);
        do_reset();
        bus_read(4'd2, d); chk("R1 ctrl after reset", {8'h0, d}, 16'h0);
        bus_read(4'd3, d); chk("R1 status after reset", {8'h0, d}, 16'h0);
        bus_read(4'd5, d); chk("R1 capture0 lo after reset", {8'h0, d}, 16'h0);
        bus_read(4'd1, d); chk("R1 low hold after reset", {8'h0, d}, 16'h0);
        read_count("R1 divide-by-1 after reset");
    endtask

    task automatic t_prescale(input logic [1:0] code);
        logic [7:0] d;
        do_reset();
        bus_write(4'd2, 8'h5C | {6'h0, code});
        idle(37);
        read_count("R2 prescale");
        idle(20);
        read_count("R2 prescale later");
        bus_read(4'd2, d);
        chk("R2 ctrl readback", {8'h0, d}, {8'h0, 8'h5C | {6'h0, code}});
    endtask

    task automatic t_lock();
        logic [7:0] d;
        do_reset();
        while (edge_n < 63) @(negedge clk);
        bus_write(4'd2, 8'h01);          // lands on edge 64: accepted
        bus_write(4'd2, 8'h7E);          // lands on edge 65: select kept
        bus_read(4'd2, d);
        chk("R5 select kept after window", {8'h0, d}, 16'h007D);
        idle(30);
        read_count("R5 divide-by-4 held");
        bus_write(4'd2, 8'h03);
        bus_read(4'd2, d);
        chk("R5 late write ignored", {8'h0, d}, 16'h0001);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        do_reset();
        while (edge_n < 65534) @(negedge clk);
        bus_read(4'd3, d);
        chk("R3 flag clear before wrap", {8'h0, d}, 16'h0);
        @(negedge clk);
        bus_read(4'd3, d);
        chk("R3 flag set by wrap", {8'h0, d}, 16'h0080);
        read_count("R3 after wrap");
        chk("R3 wrapped to low values", {8'h0, m_at_rd[15:8]}, 16'h0);
        chk("R6 irq off while disabled", {15'h0, ovf_irq}, 16'h0);
        bus_write(4'd2, 8'h80);
        chk("R6 irq on when enabled", {15'h0, ovf_irq}, 16'h1);
        bus_write(4'd3, 8'h7F);
        bus_read(4'd3, d);
        chk("R4 write 0 leaves flag", {8'h0, d}, 16'h0080);
        bus_write(4'd3, 8'h80);
        bus_read(4'd3, d);
        chk("R4 write 1 clears flag", {8'h0, d}, 16'h0);
        chk("R6 irq off after clear", {15'h0, ovf_irq}, 16'h0);
        while (edge_n < 131071) @(negedge clk);
        bus_write(4'd3, 8'h80);          // same edge as the second wrap
        bus_read(4'd3, d);
        chk("R4 wrap wins over clear", {8'h0, d}, 16'h0080);
        chk("R6 irq on after second wrap", {15'h0, ovf_irq}, 16'h1);
    endtask

    task automatic t_capture();
        logic [7:0] d;
        logic [15:0] cap1_exp;
        do_reset();
        idle(11);
        capt_strobe = 3'b001; @(negedge clk); capt_strobe = '0;
        idle(7);
        capt_strobe = 3'b100; @(negedge clk); capt_strobe = '0;
        bus_read(4'd4, d); chk("R8 capture0 hi", {8'h0, d}, {8'h0, m_cap[0][15:8]});
        bus_read(4'd5, d); chk("R8 capture0 lo", {8'h0, d}, {8'h0, m_cap[0][7:0]});
        bus_read(4'd9, d); chk("R8 capture2 lo", {8'h0, d}, {8'h0, m_cap[2][7:0]});
        idle(5);
        capt_strobe = 3'b010; bus_rd = 1'b1; bus_addr = 4'd7;
        @(negedge clk);
        capt_strobe = '0; bus_rd = 1'b0;
        cap1_exp = m_cap[1];
        chk("R9 same-cycle capture read lo", {8'h0, bus_rdata}, {8'h0, cap1_exp[7:0]});
        bus_read(4'd6, d); chk("R8 capture1 hi", {8'h0, d}, {8'h0, cap1_exp[15:8]});
        idle(3);
        capt_strobe = 3'b111; @(negedge clk); capt_strobe = '0;
        bus_read(4'd8, d); chk("R8 all strobes capture2 hi", {8'h0, d}, {8'h0, m_cap[2][15:8]});
        bus_read(4'd7, d); chk("R8 all strobes capture1 lo", {8'h0, d}, {8'h0, m_cap[2][7:0]});
    endtask

    task automatic t_latch();
        logic [7:0] d;
        do_reset();
        idle(298);
        bus_read(4'd0, d);
        chk("R7 hi byte", {8'h0, d}, {8'h0, m_at_rd[15:8]});
        exp_lo = m_at_rd[7:0];
        idle(10);
        bus_read(4'd1, d);
        chk("R7 lo byte held from hi read", {8'h0, d}, {8'h0, exp_lo});
        bus_write(4'd0, 8'hFF);
        bus_write(4'd4, 8'hAA);
        read_count("R10 counter write ignored");
        bus_read(4'd4, d);
        chk("R10 capture write ignored", {8'h0, d}, 16'h0);
        bus_read(4'd12, d);
        chk("R10 unmapped reads zero", {8'h0, d}, 16'h0);
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    n_chk++; n_fail++;
                    $display("FAIL watchdog: actual timeout expected completion");
                    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
                    $finish;
                end
            end
        join_none
        @(negedge clk);
        t_reset();
        for (int c = 0; c < 4; c++) t_prescale(2'(c));
        t_lock();
        t_capture();
        t_latch();
        t_overflow();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule